// File: doc/BRIEF.md
# Dual 8-bit Baud and Bit Timer

This block produces the serial clock for a shifter-driven SPI master. One 16-bit compare word configures it. The low byte sets how many module clock cycles each half of the serial clock lasts. The high byte sets how many serial clock edges a transfer contains. When the enable condition on the trigger is met, the timer becomes busy. It then toggles its internal clock until the edge budget is spent, and returns to idle by itself.

The trigger can be inverted. This lets a shifter's "buffer empty" flag start a transfer as soon as transmit data is written. The timer can be enabled either while the effective trigger is high or only on its rising edge. It can also stop early when the trigger falls. An idle period of one serial bit can be placed before the first edge, after the last edge, or at both points. The pin polarity can be inverted. A one-cycle shift strobe is issued on the rising or the falling internal edges, whichever is selected, so that attached shifters can sample or drive data.

Top module: `bbt_baud_timer`

## Requirements
- R1: After reset, busy, done and shift_strb are 0, and sclk_pin equals out_inv.
- R2: While a transfer runs, the internal clock toggles every cmp_val[7:0]+1 cycles. With cmp_val = 0x3F01 the serial clock period is 4 module cycles.
- R3: A transfer contains exactly cmp_val[15:8]+1 internal clock edges, then the timer leaves the running phase. With 0x3F01 this gives 64 edges, which is 32 serial clock cycles.
- R4: The effective trigger is trig_in XOR trig_inv. With en_on_rise=0 an idle timer becomes busy in the cycle after the effective trigger is seen high. With en_on_rise=1 it becomes busy only after a 0-to-1 change of the effective trigger, so a trigger held high does not start a second transfer.
- R5: With trig_inv=1 a low trig_in starts the timer and a high trig_in does not.
- R6: shift_strb is high for one cycle on every internal edge of the selected direction: rising when strb_on_fall=0, falling when strb_on_fall=1. It is high in the same cycle in which the pin shows that edge.
- R7: With start_bit_en=1, the clock stays at its idle level for 2*(cmp_val[7:0]+1) cycles after busy rises, before the normal first half-period begins.
- R8: With stop_bit_en=1, busy stays high for 2*(cmp_val[7:0]+1) cycles after the last edge, and the clock stays idle during that time.
- R9: done is a one-cycle pulse in the first cycle in which busy is low after a transfer completes.
- R10: With dis_on_trig_low=1, a low effective trigger while busy makes busy low in the next cycle, returns the clock to idle, and gives no done pulse.
- R11: sclk_pin is the internal clock XOR out_inv. Whenever the timer is idle, sclk_pin equals out_inv.
- R12: With cmp_val[7:0]=0 the internal clock toggles on every module cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmp_val | input | 16 | Compare word: [7:0] half-period minus one, [15:8] edge count minus one |
| trig_in | input | 1 | Raw trigger |
| trig_inv | input | 1 | Invert the trigger before use |
| en_on_rise | input | 1 | 1: enable on rising effective trigger, 0: enable while it is high |
| dis_on_trig_low | input | 1 | Stop at once when the effective trigger is low |
| start_bit_en | input | 1 | Insert an idle bit period before the first edge |
| stop_bit_en | input | 1 | Insert an idle bit period after the last edge |
| strb_on_fall | input | 1 | Shift strobe on falling (1) or rising (0) internal edges |
| out_inv | input | 1 | Invert the clock on the pin |
| sclk_pin | output | 1 | Serial clock to the pin |
| shift_strb | output | 1 | One-cycle shift strobe for the shifters |
| busy | output | 1 | Timer is enabled |
| done | output | 1 | Pulse when a transfer completes |

## Verification
The bench targets the exact edge count at the end of a transfer. A timer that is off by one on the high-byte counter would give 63 or 65 edges and would leave the clock parked high. It measures the delay from busy to the first edge with and without a start bit; a half-period counter that is not reloaded on enable would shorten that first half-period. It holds an edge-mode trigger high after a transfer, where a level-sensitive enable would start again at once. It also drops the trigger in the middle of a transfer with early stop enabled, where a design that finished the transfer or raised done would show up. The divide-by-one setting and the inverted pin with falling-edge strobes are compared cycle by cycle against a reference model.

// File: rtl/bbt_pkg.sv
package bbt_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_START = 2'd1,
        ST_RUN   = 2'd2,
        ST_STOP  = 2'd3
    } bbt_state_e;

    // Registered control of the timer sequencer
    typedef struct packed {
        bbt_state_e state;
        logic       half;   // second half of a start/stop bit period
        logic       sclk;   // internal clock level before polarity
        logic       strb;   // shift strobe
        logic       done;   // completion pulse
    } bbt_ctl_s;

endpackage

// File: rtl/bbt_trig_cond.sv
module bbt_trig_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic trig_in,
    input  logic trig_inv,
    input  logic en_on_rise,
    output logic trig_eff,
    output logic en_req
);
    typedef struct packed {
        logic prev;
    } trig_reg_s;

    trig_reg_s r_d, r_q;

    always_comb begin
        trig_eff = trig_in ^ trig_inv;
        r_d      = r_q;
        r_d.prev = trig_eff;
        if (en_on_rise) begin
            en_req = trig_eff && !r_q.prev;
        end else begin
            en_req = trig_eff;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end
endmodule

// File: rtl/bbt_half_div.sv
module bbt_half_div #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] reload_val,
    input  logic             clear,
    input  logic             count,
    output logic             tick
);
    typedef struct packed {
        logic [WIDTH-1:0] cnt;
    } div_reg_s;

    div_reg_s r_d, r_q;

    always_comb begin
        r_d  = r_q;
        tick = count && (r_q.cnt == '0);
        if (clear) begin
            r_d.cnt = reload_val;
        end else if (count) begin
            if (r_q.cnt == '0) begin
                r_d.cnt = reload_val;
            end else begin
                r_d.cnt = r_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end
endmodule

// File: rtl/bbt_edge_cnt.sv
module bbt_edge_cnt #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] load_val,
    input  logic             load,
    input  logic             dec,
    output logic             last
);
    typedef struct packed {
        logic [WIDTH-1:0] cnt;
    } edge_reg_s;

    edge_reg_s r_d, r_q;

    always_comb begin
        r_d  = r_q;
        last = (r_q.cnt == '0);
        if (load) begin
            r_d.cnt = load_val;
        end else if (dec && !last) begin
            r_d.cnt = r_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end
endmodule

// File: rtl/bbt_baud_timer.sv
module bbt_baud_timer #(
    parameter int HALF_W = 8,
    parameter int EDGE_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [HALF_W+EDGE_W-1:0] cmp_val,
    input  logic                     trig_in,
    input  logic                     trig_inv,
    input  logic                     en_on_rise,
    input  logic                     dis_on_trig_low,
    input  logic                     start_bit_en,
    input  logic                     stop_bit_en,
    input  logic                     strb_on_fall,
    input  logic                     out_inv,
    output logic                     sclk_pin,
    output logic                     shift_strb,
    output logic                     busy,
    output logic                     done
);
    import bbt_pkg::*;

    localparam int CMP_W = HALF_W + EDGE_W;

    logic              trig_eff;
    logic              en_req;
    logic              tick;
    logic              last_edge;
    logic              div_clear;
    logic              div_count;
    logic              edge_load;
    logic              edge_dec;
    logic [HALF_W-1:0] half_cmp;
    logic [EDGE_W-1:0] edge_cmp;

    bbt_ctl_s c_d, c_q;

    assign half_cmp = cmp_val[HALF_W-1:0];
    assign edge_cmp = cmp_val[CMP_W-1:HALF_W];

    bbt_trig_cond i_trig (
        .clk        (clk),
        .rst_n      (rst_n),
        .trig_in    (trig_in),
        .trig_inv   (trig_inv),
        .en_on_rise (en_on_rise),
        .trig_eff   (trig_eff),
        .en_req     (en_req)
    );

    bbt_half_div #(.WIDTH(HALF_W)) i_half (
        .clk        (clk),
        .rst_n      (rst_n),
        .reload_val (half_cmp),
        .clear      (div_clear),
        .count      (div_count),
        .tick       (tick)
    );

    bbt_edge_cnt #(.WIDTH(EDGE_W)) i_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_val (edge_cmp),
        .load     (edge_load),
        .dec      (edge_dec),
        .last     (last_edge)
    );

    always_comb begin
        c_d       = c_q;
        c_d.strb  = 1'b0;
        c_d.done  = 1'b0;
        div_clear = 1'b0;
        div_count = 1'b0;
        edge_load = 1'b0;
        edge_dec  = 1'b0;

        if ((c_q.state != ST_IDLE) && dis_on_trig_low && !trig_eff) begin
            // early stop: back to idle without completion
            c_d.state = ST_IDLE;
            c_d.sclk  = 1'b0;
            c_d.half  = 1'b0;
        end else begin
            unique case (c_q.state)
                ST_IDLE: begin
                    div_clear = 1'b1;
                    edge_load = 1'b1;
                    c_d.sclk  = 1'b0;
                    c_d.half  = 1'b0;
                    if (en_req) begin
                        c_d.state = start_bit_en ? ST_START : ST_RUN;
                    end
                end
                ST_START: begin
                    div_count = 1'b1;
                    if (tick) begin
                        if (c_q.half) begin
                            c_d.state = ST_RUN;
                            c_d.half  = 1'b0;
                        end else begin
                            c_d.half  = 1'b1;
                        end
                    end
                end
                ST_RUN: begin
                    div_count = 1'b1;
                    if (tick) begin
                        c_d.strb = (c_q.sclk == strb_on_fall);
                        if (last_edge) begin
                            c_d.sclk  = 1'b0;
                            c_d.state = stop_bit_en ? ST_STOP : ST_IDLE;
                            c_d.done  = !stop_bit_en;
                        end else begin
                            c_d.sclk  = !c_q.sclk;
                            edge_dec  = 1'b1;
                        end
                    end
                end
                ST_STOP: begin
                    div_count = 1'b1;
                    if (tick) begin
                        if (c_q.half) begin
                            c_d.state = ST_IDLE;
                            c_d.half  = 1'b0;
                            c_d.done  = 1'b1;
                        end else begin
                            c_d.half  = 1'b1;
                        end
                    end
                end
                default: begin
                    c_d.state = ST_IDLE;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '{state: ST_IDLE, half: 1'b0, sclk: 1'b0, strb: 1'b0, done: 1'b0};
        end else begin
            c_q <= c_d;
        end
    end

    assign sclk_pin   = c_q.sclk ^ out_inv;
    assign shift_strb = c_q.strb;
    assign busy       = (c_q.state != ST_IDLE);
    assign done       = c_q.done;

endmodule

// File: rtl/bbt_baud_timer_chk.sv
module bbt_baud_timer_chk (
    input logic clk,
    input logic rst_n,
    input logic trig_in,
    input logic trig_inv,
    input logic en_on_rise,
    input logic dis_on_trig_low,
    input logic out_inv,
    input logic sclk_pin,
    input logic shift_strb,
    input logic busy,
    input logic done
);
    // R6
    strb_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shift_strb |=> !shift_strb);

    // R6
    strb_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shift_strb |-> $past(busy));

    // R9
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));

    // R9
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R11
    idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (sclk_pin == out_inv));

    // R4
    level_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !en_on_rise && (trig_in ^ trig_inv)) |=> busy);

    // R10
    early_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && dis_on_trig_low && !(trig_in ^ trig_inv)) |=> (!busy && !done));
endmodule

bind bbt_baud_timer bbt_baud_timer_chk i_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .trig_in         (trig_in),
    .trig_inv        (trig_inv),
    .en_on_rise      (en_on_rise),
    .dis_on_trig_low (dis_on_trig_low),
    .out_inv         (out_inv),
    .sclk_pin        (sclk_pin),
    .shift_strb      (shift_strb),
    .busy            (busy),
    .done            (done)
);

// File: tb/test_bbt_baud_timer.sv
`timescale 1ns/1ps
module test_bbt_baud_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cmp_val = 16'h3F01;
    logic        trig_in = 1'b0, trig_inv = 1'b0, en_on_rise = 1'b0;
    logic        dis_on_trig_low = 1'b0, start_bit_en = 1'b0, stop_bit_en = 1'b0;
    logic        strb_on_fall = 1'b0, out_inv = 1'b0;
    logic        sclk_pin, shift_strb, busy, done;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    bbt_baud_timer i_bbt_baud_timer (
        .clk(clk), .rst_n(rst_n), .cmp_val(cmp_val), .trig_in(trig_in),
        .trig_inv(trig_inv), .en_on_rise(en_on_rise), .dis_on_trig_low(dis_on_trig_low),
        .start_bit_en(start_bit_en), .stop_bit_en(stop_bit_en),
        .strb_on_fall(strb_on_fall), .out_inv(out_inv),
        .sclk_pin(sclk_pin), .shift_strb(shift_strb), .busy(busy), .done(done)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference ----------------
    int m_phase = 0;   // 0 idle, 1 lead bit, 2 clocking, 3 trail bit
    int m_elapsed = 0, m_left = 0, m_second = 0;
    bit m_clk = 0, m_strb = 0, m_done = 0, m_prev = 0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_phase = 0; m_clk = 0; m_strb = 0; m_done = 0; m_prev = 0;
            m_elapsed = 0; m_left = 0; m_second = 0;
        end else begin
            bit te, st, dn, boundary;
            int half_len;
            te = trig_in ^ trig_inv;
            half_len = int'(cmp_val[7:0]);
            st = 0; dn = 0;
            if (m_phase != 0 && dis_on_trig_low && !te) begin
                m_phase = 0; m_clk = 0;
            end else if (m_phase == 0) begin
                m_elapsed = 0; m_second = 0; m_clk = 0;
                m_left = int'(cmp_val[15:8]) + 1;
                if (en_on_rise ? (te && !m_prev) : te)
                    m_phase = start_bit_en ? 1 : 2;
            end else begin
                boundary = (m_elapsed == half_len);
                m_elapsed = boundary ? 0 : m_elapsed + 1;
                if (boundary) begin
                    if (m_phase == 2) begin
                        st = (m_clk == strb_on_fall);
                        m_left--;
                        if (m_left == 0) begin
                            m_clk = 0;
                            if (stop_bit_en) begin m_phase = 3; m_second = 0; end
                            else begin m_phase = 0; dn = 1; end
                        end else m_clk = !m_clk;
                    end else if (m_second == 1) begin
                        m_second = 0;
                        if (m_phase == 1) m_phase = 2;
                        else begin m_phase = 0; dn = 1; end
                    end else m_second = 1;
                end
            end
            m_prev = te; m_strb = st; m_done = dn;
        end
    end

    // ---------------- per-cycle comparison and measurement ----------------
    int cyc = 0, toggles = 0, strobes = 0, rises = 0, dones = 0;
    int t_busy = -1, t_first = -1, t_last = -1, t_done = -1;
    bit prev_pin = 0, prev_busy = 0;

    task automatic clear_meas();
        toggles = 0; strobes = 0; rises = 0; dones = 0;
        t_busy = -1; t_first = -1; t_last = -1; t_done = -1;
    endtask

    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            chk("R2 R11 pin vs model", int'(sclk_pin), int'(m_clk ^ out_inv));
            chk("R6 strobe vs model", int'(shift_strb), int'(m_strb));
            chk("R4 busy vs model", int'(busy), int'(m_phase != 0));
            chk("R9 done vs model", int'(done), int'(m_done));
            if (sclk_pin != prev_pin) begin
                toggles++;
                if (t_first < 0) t_first = cyc;
                t_last = cyc;
            end
            if (shift_strb) strobes++;
            if (busy && !prev_busy) begin rises++; if (t_busy < 0) t_busy = cyc; end
            if (done) begin dones++; t_done = cyc; end
        end
        prev_pin = sclk_pin; prev_busy = busy;
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wait_done(input int limit);
        for (int i = 0; i < limit; i++) begin
            step(1);
            if (dones > 0) break;
        end
        step(2);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        // R1 reset state
        #1;
        chk("R1 busy at reset", int'(busy), 0);
        chk("R1 strobe at reset", int'(shift_strb), 0);
        chk("R1 done at reset", int'(done), 0);
        chk("R1 pin at reset", int'(sclk_pin), 0);
        step(3);
        rst_n = 1'b1;
        step(2);

        // A: 32-bit transfer at divide by 4 (R2, R3, R6, R9)
        cmp_val = 16'h3F01; step(1); clear_meas();
        trig_in = 1'b1; step(1); trig_in = 1'b0;
        wait_done(400);
        chk("R3 edges for 0x3F01", toggles, 64);
        chk("R6 rising strobes", strobes, 32);
        chk("R2 first edge delay", t_first - t_busy, 2);
        chk("R2 edge spacing", t_last - t_first, 63 * 2);
        chk("R9 done at last edge", t_done - t_last, 0);
        chk("R9 one done", dones, 1);

        // B: rising-edge enable, trigger held high (R4)
        en_on_rise = 1'b1; cmp_val = 16'h0301; step(2); clear_meas();
        trig_in = 1'b1;
        wait_done(100);
        step(20);
        chk("R4 single start while held high", rises, 1);
        chk("R4 idle while held high", int'(busy), 0);
        trig_in = 1'b0; en_on_rise = 1'b0; step(2);

        // C: inverted trigger, divide by one (R5, R12)
        trig_in = 1'b1; trig_inv = 1'b1; cmp_val = 16'h0100; step(3); clear_meas();
        chk("R5 high raw trigger ignored", int'(busy), 0);
        trig_in = 1'b0; step(1); trig_in = 1'b1;
        wait_done(50);
        chk("R5 low raw trigger starts", rises, 1);
        chk("R12 first edge delay", t_first - t_busy, 1);
        chk("R12 edges", toggles, 2);
        trig_inv = 1'b0; trig_in = 1'b0; step(2);

        // D: start and stop bits (R7, R8)
        start_bit_en = 1'b1; stop_bit_en = 1'b1; cmp_val = 16'h0302; step(1); clear_meas();
        trig_in = 1'b1; step(1); trig_in = 1'b0;
        wait_done(200);
        chk("R7 lead idle then half period", t_first - t_busy, 6 + 3);
        chk("R8 trail idle", t_done - t_last, 6);
        chk("R3 edges with framing", toggles, 4);
        start_bit_en = 1'b0; stop_bit_en = 1'b0; step(2);

        // E: inverted pin, falling strobes (R11, R6)
        out_inv = 1'b1; strb_on_fall = 1'b1; cmp_val = 16'h0501; step(2); clear_meas();
        chk("R11 idle pin inverted", int'(sclk_pin), 1);
        trig_in = 1'b1; step(1); trig_in = 1'b0;
        wait_done(100);
        chk("R6 falling strobes", strobes, 3);
        chk("R11 edges on inverted pin", toggles, 6);
        chk("R11 pin back to idle", int'(sclk_pin), 1);
        out_inv = 1'b0; strb_on_fall = 1'b0; step(2);

        // F: early stop on trigger low (R10)
        dis_on_trig_low = 1'b1; cmp_val = 16'h3F03; step(1); clear_meas();
        trig_in = 1'b1; step(10); trig_in = 1'b0; step(1);
        chk("R10 busy cleared", int'(busy), 0);
        step(10);
        chk("R10 no done on stop", dones, 0);
        chk("R10 pin idle", int'(sclk_pin), 0);
        dis_on_trig_low = 1'b0; step(2);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule